// File: doc/BRIEF.md
# Hot-Swap Slot Power Fault Controller

This block holds the digital control for one hot-plug card slot that feeds three rails: a 12 V main rail, a 3.3 V main rail and an auxiliary rail. A card-presence input has to stay active for a programmable debounce time before any rail may switch on. If presence is lost, the rails go off at once. The main rails follow the ON control input and the auxiliary rail follows the AUXEN control input. Both are gated by the debounced presence.

Comparator flags report overcurrent, undervoltage and overtemperature. These flags set two sticky fault latches, one for the main rails and one for the auxiliary rail, and a set latch keeps its rails off. Software clears a latch by taking the matching control input low and holding it low for a minimum number of cycles. A diagnostic force-on input overrides every protection except the auxiliary undervoltage lockout. All inputs are asynchronous and pass through two-flop synchronizers. All time limits are parameters given in clock cycles.

Top module: `hs_slot_ctrl`

## Requirements
- R1: After reset, all three enables are 0, pwrgd_n, dly_pwrgd_n, fault_main_n, fault_aux_n and irq_n are 1, and the presence debounce counter is zero.
- R2: The slot counts as present only after the synchronized card_present_n has been 0 for DEBOUNCE_CYC consecutive clock edges. Before that, all enables stay 0 (force-on excepted).
- R3: When the synchronized presence goes inactive, all three enables drop in that same cycle, which is two clock edges after the pin rises. No debounce applies to removal.
- R4: en_12v and en_3v3 are 1 when ON is high, the slot is present and no main fault is latched. en_aux is 1 when AUXEN is high, the slot is present, no aux fault is latched and aux_uv is 0.
- R5: oc_12v, oc_3v3 or main_uv set the main fault latch. fault_main_n then reads 0 and both main enables turn off.
- R6: aux_oc or over_temp set the aux fault latch. fault_aux_n then reads 0 and en_aux turns off.
- R7: The main latch clears only when the synchronized ON has gone from 1 to 0 and stayed 0 for MAIN_CLR_CYC sampled cycles. A shorter low pulse has no effect. If a fault condition is still present, it sets the latch again, because set wins over clear.
- R8: The aux latch clears in the same way through AUXEN with AUX_CLR_CYC. Each control input clears only its own latch.
- R9: While force_on_n is 0, all three rails are on whatever the presence, faults, overcurrent, thermal or main undervoltage state, and no fault latches. aux_uv still forces en_aux to 0.
- R10: While force_on_n is 0, pwrgd_n and dly_pwrgd_n read 0, and fault_main_n, fault_aux_n and irq_n read 1.
- R11: pwrgd_n is the inverse of the main-rail enable. dly_pwrgd_n goes to 0 after the main enable has been 1 for PG_DELAY_CYC consecutive edges, and returns to 1 in the same cycle the main enable falls.
- R12: irq_n is 0 whenever either fault latch is set (force-on excepted).
- R13: Every input reaches the logic through two synchronizer flops, so an input change shows at the outputs no earlier than two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_present_n | input | 1 | Card presence, active low |
| main_on | input | 1 | Main rails request; falling pulse clears main fault |
| aux_on | input | 1 | Aux rail request; falling pulse clears aux fault |
| force_on_n | input | 1 | Diagnostic override, active low |
| oc_12v | input | 1 | 12 V overcurrent flag |
| oc_3v3 | input | 1 | 3.3 V overcurrent flag |
| main_uv | input | 1 | Main input undervoltage flag |
| aux_oc | input | 1 | Aux overcurrent flag |
| over_temp | input | 1 | Overtemperature flag |
| aux_uv | input | 1 | Aux undervoltage lockout flag |
| en_12v | output | 1 | 12 V rail enable |
| en_3v3 | output | 1 | 3.3 V rail enable |
| en_aux | output | 1 | Aux rail enable |
| pwrgd_n | output | 1 | Power good, active low |
| dly_pwrgd_n | output | 1 | Delayed power good, active low |
| fault_main_n | output | 1 | Main fault, active low |
| fault_aux_n | output | 1 | Aux fault, active low |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The assertions assume that the control and flag inputs are ordinary levels that the synchronizers sample. They also assume that no more than one clear pulse is judged at a time per latch, and that reset is applied before the first clock edge that matters. The stimulus changes inputs only on the falling clock edge. Fault flags fire rarely and as short bursts, and control inputs are held for long stretches. As a result, debounce windows, clear windows and delayed power-good windows all finish as well as get cut short. Directed sequences pin down the exact edge at which presence qualifies, presence loss, short and long clear pulses, and force-on together with aux undervoltage.

// File: rtl/hs_slot_pkg.sv
package hs_slot_pkg;
  localparam int NUM_IN = 10;
  localparam int IX_PRES  = 0;
  localparam int IX_ON    = 1;
  localparam int IX_AUXEN = 2;
  localparam int IX_FORCE = 3;
  localparam int IX_OC12  = 4;
  localparam int IX_OC3   = 5;
  localparam int IX_MUV   = 6;
  localparam int IX_AOC   = 7;
  localparam int IX_OT    = 8;
  localparam int IX_AUV   = 9;
  // active-low inputs idle high: presence and force-on
  localparam logic [NUM_IN-1:0] IN_IDLE = NUM_IN'((1 << IX_PRES) | (1 << IX_FORCE));
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hs_qualify.sv
// Asserts ok once act has been high for LIMIT consecutive edges; ok drops with act.
module hs_qualify #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  output logic ok
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;
  logic          held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      held <= 1'b0;
    end else if (!act) begin
      cnt  <= '0;
      held <= 1'b0;
    end else if (!held) begin
      if (cnt == LAST) held <= 1'b1;
      else             cnt  <= cnt + 1'b1;
    end
  end

  assign ok = held & act;

  // covers presence debounce (R2) and delayed power good (R11)
  assert_hold_before_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> $past(act));
endmodule

// File: rtl/hs_clr_timer.sv
// One-cycle clear strobe once ctl has stayed low LEN sampled cycles after being high.
module hs_clr_timer #(
  parameter int LEN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl,
  output logic clr
);
  localparam int RW = $clog2(LEN + 1);
  localparam logic [RW-1:0] LAST = RW'(LEN - 1);
  localparam logic [RW-1:0] FULL = RW'(LEN);

  logic [RW-1:0] run;
  logic          was_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= '0;
      was_high <= 1'b0;
    end else if (ctl) begin
      run      <= '0;
      was_high <= 1'b1;
    end else if (was_high && run != FULL) begin
      run <= run + 1'b1;
    end
  end

  assign clr = !ctl && was_high && (run == LAST);

  generate
    if (LEN > 1) begin : g_chk
      assert_clr_needs_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> $past(!ctl));
    end
  endgenerate
endmodule

// File: rtl/hs_fault_latch.sv
module hs_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/hs_slot_ctrl.sv
module hs_slot_ctrl #(
  parameter int DEBOUNCE_CYC  = 500000,
  parameter int MAIN_CLR_CYC  = 10,
  parameter int AUX_CLR_CYC   = 25,
  parameter int PG_DELAY_CYC  = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic card_present_n,
  input  logic main_on,
  input  logic aux_on,
  input  logic force_on_n,
  input  logic oc_12v,
  input  logic oc_3v3,
  input  logic main_uv,
  input  logic aux_oc,
  input  logic over_temp,
  input  logic aux_uv,
  output logic en_12v,
  output logic en_3v3,
  output logic en_aux,
  output logic pwrgd_n,
  output logic dly_pwrgd_n,
  output logic fault_main_n,
  output logic fault_aux_n,
  output logic irq_n
);
  import hs_slot_pkg::*;

  logic [NUM_IN-1:0] raw, s;
  logic pres_act, pres_ok, force_a;
  logic main_set, aux_set, main_clr, aux_clr;
  logic main_flt, aux_flt;
  logic main_en, pg_late;

  always_comb begin
    raw           = '0;
    raw[IX_PRES]  = card_present_n;
    raw[IX_ON]    = main_on;
    raw[IX_AUXEN] = aux_on;
    raw[IX_FORCE] = force_on_n;
    raw[IX_OC12]  = oc_12v;
    raw[IX_OC3]   = oc_3v3;
    raw[IX_MUV]   = main_uv;
    raw[IX_AOC]   = aux_oc;
    raw[IX_OT]    = over_temp;
    raw[IX_AUV]   = aux_uv;
  end

  hs_sync #(.W(NUM_IN), .RST_VAL(IN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(s));

  assign pres_act = !s[IX_PRES];
  assign force_a  = !s[IX_FORCE];

  hs_qualify #(.LIMIT(DEBOUNCE_CYC)) u_pres_db (
    .clk(clk), .rst_n(rst_n), .act(pres_act), .ok(pres_ok));

  assign main_set = !force_a && (s[IX_OC12] || s[IX_OC3] || s[IX_MUV]);
  assign aux_set  = !force_a && (s[IX_AOC] || s[IX_OT]);

  hs_clr_timer #(.LEN(MAIN_CLR_CYC)) u_main_clr (
    .clk(clk), .rst_n(rst_n), .ctl(s[IX_ON]), .clr(main_clr));
  hs_clr_timer #(.LEN(AUX_CLR_CYC)) u_aux_clr (
    .clk(clk), .rst_n(rst_n), .ctl(s[IX_AUXEN]), .clr(aux_clr));

  hs_fault_latch u_main_flt (
    .clk(clk), .rst_n(rst_n), .set(main_set), .clr(main_clr), .flag(main_flt));
  hs_fault_latch u_aux_flt (
    .clk(clk), .rst_n(rst_n), .set(aux_set), .clr(aux_clr), .flag(aux_flt));

  assign main_en = force_a || (pres_ok && s[IX_ON] && !main_flt);

  hs_qualify #(.LIMIT(PG_DELAY_CYC)) u_pg_dly (
    .clk(clk), .rst_n(rst_n), .act(main_en), .ok(pg_late));

  assign en_12v       = main_en;
  assign en_3v3       = main_en;
  assign en_aux       = !s[IX_AUV] && (force_a || (pres_ok && s[IX_AUXEN] && !aux_flt));
  assign pwrgd_n      = !main_en;
  assign dly_pwrgd_n  = !(force_a || pg_late);
  assign fault_main_n = !(main_flt && !force_a);
  assign fault_aux_n  = !(aux_flt && !force_a);
  assign irq_n        = !((main_flt || aux_flt) && !force_a);

  assert_loss_cuts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pres_act && !force_a) |-> !(en_12v || en_3v3 || en_aux));
  assert_aux_uv_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s[IX_AUV] |-> !en_aux);
  assert_force_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    force_a |-> (fault_main_n && fault_aux_n && irq_n && !dly_pwrgd_n));
  assert_fault_blocks_main_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (main_flt && !force_a) |-> !en_12v);
endmodule

// File: tb/tb_hs_slot_ctrl.sv
`timescale 1ns/1ps
module tb_hs_slot_ctrl;
  localparam int DEB = 40, MCLR = 10, ACLR = 25, PGD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  bit [9:0] drv = 10'b0000001001;

  logic en_12v, en_3v3, en_aux, pwrgd_n, dly_pwrgd_n, fault_main_n, fault_aux_n, irq_n;

  hs_slot_ctrl #(.DEBOUNCE_CYC(DEB), .MAIN_CLR_CYC(MCLR), .AUX_CLR_CYC(ACLR),
                 .PG_DELAY_CYC(PGD)) dut (
    .clk(clk), .rst_n(rst_n), .card_present_n(drv[0]), .main_on(drv[1]),
    .aux_on(drv[2]), .force_on_n(drv[3]), .oc_12v(drv[4]), .oc_3v3(drv[5]),
    .main_uv(drv[6]), .aux_oc(drv[7]), .over_temp(drv[8]), .aux_uv(drv[9]),
    .en_12v(en_12v), .en_3v3(en_3v3), .en_aux(en_aux), .pwrgd_n(pwrgd_n),
    .dly_pwrgd_n(dly_pwrgd_n), .fault_main_n(fault_main_n),
    .fault_aux_n(fault_aux_n), .irq_n(irq_n));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0, cmp_on = 0;

  // reference model state
  bit [9:0] p1 = 10'b0000001001, p2 = 10'b0000001001;
  int dcnt = 0, gcnt = 0, runm = 0, runa = 0;
  bit dok = 0, gok = 0, hm = 0, ha = 0, fm = 0, fa = 0;

  function automatic bit m_force(); return !p2[3]; endfunction
  function automatic bit m_pres(); return dok && !p2[0]; endfunction
  function automatic bit m_main(); return m_force() || (m_pres() && p2[1] && !fm); endfunction
  function automatic bit m_aux();
    return !p2[9] && (m_force() || (m_pres() && p2[2] && !fa));
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      p1 = 10'b0000001001; p2 = 10'b0000001001;
      dcnt = 0; gcnt = 0; runm = 0; runa = 0;
      dok = 0; gok = 0; hm = 0; ha = 0; fm = 0; fa = 0;
    end else begin
      bit me, cm, ca, sm, sa, act;
      me  = m_main();
      act = !p2[0];
      cm  = !p2[1] && hm && (runm == MCLR - 1);
      ca  = !p2[2] && ha && (runa == ACLR - 1);
      sm  = !m_force() && (p2[4] || p2[5] || p2[6]);
      sa  = !m_force() && (p2[7] || p2[8]);
      if (sm) fm = 1; else if (cm) fm = 0;
      if (sa) fa = 1; else if (ca) fa = 0;
      if (p2[1]) begin runm = 0; hm = 1; end else if (hm && runm < MCLR) runm++;
      if (p2[2]) begin runa = 0; ha = 1; end else if (ha && runa < ACLR) runa++;
      if (!act) begin dcnt = 0; dok = 0; end
      else if (!dok) begin if (dcnt == DEB - 1) dok = 1; else dcnt++; end
      if (!me) begin gcnt = 0; gok = 0; end
      else if (!gok) begin if (gcnt == PGD - 1) gok = 1; else gcnt++; end
      p2 = p1; p1 = drv;
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // every-cycle comparison against the model, away from the active edge
  always @(negedge clk) if (cmp_on && rst_n) begin
    bit f;
    f = m_force();
    chk("R4", "en_12v", en_12v, m_main());
    chk("R4", "en_3v3", en_3v3, m_main());
    chk("R4", "en_aux", en_aux, m_aux());
    chk("R11", "pwrgd_n", pwrgd_n, !m_main());
    chk("R11", "dly_pwrgd_n", dly_pwrgd_n, !(f || (gok && m_main())));
    chk("R5", "fault_main_n", fault_main_n, !(fm && !f));
    chk("R6", "fault_aux_n", fault_aux_n, !(fa && !f));
    chk("R12", "irq_n", irq_n, !((fm || fa) && !f));
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // watchdog
  always @(posedge clk) if (!done && cyc > 150000) begin
    done = 1; fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    step(3);
    // R1 reset state
    chk("R1", "en_12v", en_12v, 0); chk("R1", "en_aux", en_aux, 0);
    chk("R1", "pwrgd_n", pwrgd_n, 1); chk("R1", "fault_main_n", fault_main_n, 1);
    chk("R1", "irq_n", irq_n, 1);
    rst_n = 1; cmp_on = 1;
    step(2);
    // R2 debounce: presence + ON + AUXEN applied together
    drv[0] = 0; drv[1] = 1; drv[2] = 1;
    step(2 + DEB - 1);
    chk("R2", "en_12v one edge early", en_12v, 0);
    step(1);
    chk("R2", "en_12v qualified", en_12v, 1);
    chk("R2", "en_aux qualified", en_aux, 1);
    step(PGD + 2);
    chk("R11", "dly_pwrgd_n after delay", dly_pwrgd_n, 0);
    // R3 removal is immediate after sync (R13 latency)
    drv[0] = 1;
    step(1);
    chk("R13", "en_12v still on one edge after removal", en_12v, 1);
    step(1);
    chk("R3", "en_12v cut", en_12v, 0);
    chk("R3", "en_aux cut", en_aux, 0);
    chk("R11", "dly_pwrgd_n drops", dly_pwrgd_n, 1);
    drv[0] = 0; step(DEB + 6);
    // R5 main fault, R7 short and long clear
    drv[4] = 1; step(1); drv[4] = 0; step(3);
    chk("R5", "fault_main_n set", fault_main_n, 0);
    chk("R5", "en_12v off", en_12v, 0);
    chk("R12", "irq_n", irq_n, 0);
    drv[1] = 0; step(MCLR - 1); drv[1] = 1; step(4);
    chk("R7", "short pulse ignored", fault_main_n, 0);
    // R6 aux fault from overtemp; R8 AUXEN clears only aux
    drv[8] = 1; step(1); drv[8] = 0; step(3);
    chk("R6", "fault_aux_n set", fault_aux_n, 0);
    drv[2] = 0; step(ACLR + 3); drv[2] = 1; step(3);
    chk("R8", "aux cleared", fault_aux_n, 1);
    chk("R8", "main untouched by AUXEN", fault_main_n, 0);
    drv[1] = 0; step(MCLR + 3); drv[1] = 1; step(3);
    chk("R7", "long pulse clears", fault_main_n, 1);
    chk("R7", "rails back", en_12v, 1);
    // R7 condition persists: clear does not stick
    drv[6] = 1; drv[1] = 0; step(MCLR + 4); drv[1] = 1; step(3);
    chk("R7", "persisting uv keeps fault", fault_main_n, 0);
    drv[6] = 0;
    // R9/R10 force-on with presence gone, fault latched, aux uv
    drv[0] = 1; drv[9] = 1; drv[3] = 0; drv[7] = 1; step(3);
    chk("R9", "en_12v forced", en_12v, 1);
    chk("R9", "aux uv still locks", en_aux, 0);
    chk("R10", "fault_main_n released", fault_main_n, 1);
    chk("R10", "dly_pwrgd_n asserted", dly_pwrgd_n, 0);
    drv[9] = 0; step(3);
    chk("R9", "en_aux forced", en_aux, 1);
    drv[3] = 1; drv[7] = 0; drv[0] = 0; step(4);
    chk("R9", "no aux latch during force", fault_aux_n, 1);
    // constrained random phase
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      if ($urandom_range(299) == 0) drv[0] = ~drv[0];
      if ($urandom_range(59) == 0)  drv[1] = ~drv[1];
      if ($urandom_range(79) == 0)  drv[2] = ~drv[2];
      drv[3] = ($urandom_range(999) < 3) ? 1'b0 : (drv[3] | ($urandom_range(19) == 0));
      for (int b = 4; b < 10; b++) drv[b] = ($urandom_range(399) == 0);
    end
    step(4);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule